// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Single-Byte Receive Holding

A host-side peripheral that sends and receives asynchronous serial characters (one start bit, eight data bits sent least significant first, one stop bit) and presents them to a processor through three 32-bit registers on a simple single-cycle bus. The bus has an address, a read strobe, a write strobe, write data and read data. Read data is combinational and valid in the same cycle as the read strobe.

Software sends a character by writing its low byte to the transmit register. It receives by polling the status word and then reading the receive register. The receiver keeps exactly one character. Until software collects that character, every later complete frame is thrown away and reported on an overrun pulse. Reading the receive register acknowledges the character. Writes to the status word do nothing. Any access outside the three decoded words is flagged on a one-cycle error pulse. The bit period is fixed at elaboration by a clocks-per-bit parameter.

Top module: `uart_mmio`

## Requirements
- R1: After reset, the status word (byte offset 0x14) reads 0x00000002, the receive register (offset 0x04) reads zero, the serial output idles high, and the overrun and access-error outputs are low.
- R2: A write to offset 0x00 while the transmitter is idle sends bits 7:0 of the write data as one frame on the serial output. The frame is a low start bit, the data bits least significant first and a high stop bit, and each bit lasts CLKS_PER_BIT clocks, starting at the clock edge that takes the write.
- R3: Status bit 1 (transmitter ready) is clear from the edge that takes a transmit write until exactly 10*CLKS_PER_BIT clocks after that edge, and then it is set again.
- R4: A transmit write while status bit 1 is clear is dropped. The frame in progress is unchanged and no further frame follows it.
- R5: A complete frame on the serial input, received while status bit 0 (receive ready) is clear, is stored and sets status bit 0. Reading offset 0x04 returns the byte in bits 7:0, with the upper bits zero.
- R6: A read of offset 0x04 clears status bit 0 from the next clock edge.
- R7: A complete frame that arrives while status bit 0 is set is discarded, and the overrun output pulses high for one cycle. The held byte and status bit 0 are kept.
- R8: Writes to offset 0x14 are accepted and change neither status bit, and they start no transmission.
- R9: Accesses to any other byte address, including misaligned addresses, read zero and change no state. For each such access, the access-error output is high for exactly the one cycle after it.
- R10: The receiver samples each bit at mid-bit. A low glitch on the serial input shorter than half a bit time starts no reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the strobe cycle |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| overrun | output | 1 | One-cycle pulse when a frame is discarded |
| accessErr | output | 1 | One-cycle pulse after an access to an unmapped address |

## Verification
Read data is due in the same cycle as the read strobe, so the bench samples it 1 ns after raising the strobe. The receive-ready flag, the access-error pulse and the start of a transmit frame all appear at the edge that takes the access, so the bench checks them at the falling edge that follows it. The bench samples transmit bits at their centres. It counts falling edges from the load edge, samples bit i at CLKS_PER_BIT/2 + i*CLKS_PER_BIT, and checks the ready flag at both 10*CLKS_PER_BIT-1 and 10*CLKS_PER_BIT. Received frames are held for a full stop bit plus a few cycles before the status is polled, which covers the two-flop synchroniser and the mid-bit decision.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;
  // Byte offsets decoded by the register window.
  localparam int unsigned OFS_TX   = 'h00;
  localparam int unsigned OFS_RX   = 'h04;
  localparam int unsigned OFS_STAT = 'h14;

  // Status word bit positions.
  localparam int unsigned ST_RX_READY = 0;
  localparam int unsigned ST_TX_READY = 1;

  // Strobes issued by the decoder to the datapath.
  typedef struct packed {
    logic txLoad;   // accepted transmit write
    logic rxPop;    // read of the receive register
  } dpStrobe_t;
endpackage

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       load,
  input  logic [7:0] data,
  output logic       txd,
  output logic       busy
);
  localparam int unsigned CNT_W   = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int unsigned FRAME_W = 10;

  logic [CNT_W-1:0]   clkCnt;
  logic [3:0]         bitCnt;
  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      clkCnt   <= '0;
      bitCnt   <= '0;
      shiftReg <= '1;
    end else if (load && !busy) begin
      busy     <= 1'b1;
      clkCnt   <= '0;
      bitCnt   <= '0;
      shiftReg <= {1'b1, data, 1'b0};
    end else if (busy) begin
      if (clkCnt == CNT_W'(CLKS_PER_BIT - 1)) begin
        clkCnt   <= '0;
        shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
        if (bitCnt == 4'(FRAME_W - 1)) busy <= 1'b0;
        else bitCnt <= bitCnt + 4'd1;
      end else begin
        clkCnt <= clkCnt + CNT_W'(1);
      end
    end
  end

  assign txd = busy ? shiftReg[0] : 1'b1;

  // The bit counter never runs past the stop bit.
  assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitCnt < 4'(FRAME_W)));
endmodule

// File: rtl/uart_rx.sv
module uart_rx #(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] byteOut
);
  localparam int unsigned CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int unsigned HALF  = CLKS_PER_BIT / 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;

  rxState_t         state;
  logic [1:0]       syncReg;
  logic [CNT_W-1:0] clkCnt;
  logic [2:0]       bitIdx;
  logic [7:0]       shiftReg;
  logic             rxS;

  assign rxS     = syncReg[1];
  assign byteOut = shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      syncReg  <= 2'b11;
      clkCnt   <= '0;
      bitIdx   <= '0;
      shiftReg <= '0;
      done     <= 1'b0;
    end else begin
      syncReg <= {syncReg[0], rxd};
      done    <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          clkCnt <= '0;
          if (!rxS) state <= RX_START;
        end
        RX_START: begin
          if (clkCnt == CNT_W'(HALF - 1)) begin
            clkCnt <= '0;
            bitIdx <= '0;
            state  <= rxS ? RX_IDLE : RX_DATA;
          end else begin
            clkCnt <= clkCnt + CNT_W'(1);
          end
        end
        RX_DATA: begin
          if (clkCnt == CNT_W'(CLKS_PER_BIT - 1)) begin
            clkCnt   <= '0;
            shiftReg <= {rxS, shiftReg[7:1]};
            if (bitIdx == 3'd7) state <= RX_STOP;
            else bitIdx <= bitIdx + 3'd1;
          end else begin
            clkCnt <= clkCnt + CNT_W'(1);
          end
        end
        RX_STOP: begin
          if (clkCnt == CNT_W'(CLKS_PER_BIT - 1)) begin
            clkCnt <= '0;
            state  <= RX_IDLE;
            if (rxS) done <= 1'b1;
          end else begin
            clkCnt <= clkCnt + CNT_W'(1);
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // A frame completes only out of the stop phase.
  assert_done_from_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(state == RX_STOP));
  // A start glitch that is gone at mid-bit returns to idle.
  assert_glitch_reject_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_START && clkCnt == CNT_W'(HALF - 1) && rxS) |=> state == RX_IDLE);
endmodule

// File: rtl/uart_dpath.sv
module uart_dpath
  import uart_mmio_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic [7:0] txByte,
  input  logic       rxd,
  output logic       txd,
  output logic       txReady,
  output logic       rxReady,
  output logic [7:0] rxHold,
  output logic       overrun
);
  logic       txBusy;
  logic       rxDone;
  logic [7:0] rxNew;

  uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) txUnit (
    .clk(clk), .rstN(rstN), .load(strobe.txLoad), .data(txByte),
    .txd(txd), .busy(txBusy)
  );

  uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) rxUnit (
    .clk(clk), .rstN(rstN), .rxd(rxd), .done(rxDone), .byteOut(rxNew)
  );

  assign txReady = !txBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReady <= 1'b0;
      rxHold  <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= rxDone && rxReady;
      if (rxDone && !rxReady) begin
        rxHold  <= rxNew;
        rxReady <= 1'b1;
      end else if (strobe.rxPop) begin
        rxReady <= 1'b0;
      end
    end
  end

  assert_tx_busy_after_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoad |=> !txReady);
  assert_tx_load_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoad |-> txReady);
  assert_pop_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rxPop && !rxDone) |=> !rxReady);
  assert_hold_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |=> $stable(rxHold));
  assert_overrun_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxReady) |=> overrun);
endmodule

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_mmio_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              rxReady,
  input  logic              txReady,
  input  logic [7:0]        rxHold,
  output dpStrobe_t         strobe,
  output logic [7:0]        txByte,
  output logic [DATA_W-1:0] busRdata,
  output logic              accessErr
);
  logic hitTx, hitRx, hitStat, mapped;
  logic unusedWdata;

  assign hitTx   = busAddr == ADDR_W'(OFS_TX);
  assign hitRx   = busAddr == ADDR_W'(OFS_RX);
  assign hitStat = busAddr == ADDR_W'(OFS_STAT);
  assign mapped  = hitTx || hitRx || hitStat;

  assign txByte       = busWdata[7:0];
  assign unusedWdata  = ^busWdata[DATA_W-1:8];
  assign strobe.txLoad = busWr && hitTx && txReady;
  assign strobe.rxPop  = busRd && hitRx;

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      if (hitRx) busRdata[7:0] = rxHold;
      if (hitStat) begin
        busRdata[ST_RX_READY] = rxReady;
        busRdata[ST_TX_READY] = txReady;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) accessErr <= 1'b0;
    else accessErr <= (busRd || busWr) && !mapped;
  end

  assert_err_follows_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> $past(busRd || busWr));
endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
  import uart_mmio_pkg::*;
#(
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxd,
  output logic              txd,
  output logic              overrun,
  output logic              accessErr
);
  dpStrobe_t  strobe;
  logic [7:0] txByte;
  logic [7:0] rxHold;
  logic       rxReady;
  logic       txReady;

  uart_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .rxReady(rxReady), .txReady(txReady), .rxHold(rxHold),
    .strobe(strobe), .txByte(txByte), .busRdata(busRdata), .accessErr(accessErr)
  );

  uart_dpath #(.CLKS_PER_BIT(CLKS_PER_BIT)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txByte(txByte), .rxd(rxd),
    .txd(txd), .txReady(txReady), .rxReady(rxReady), .rxHold(rxHold),
    .overrun(overrun)
  );
endmodule

// File: tb/tb_uart_mmio.sv
module tb_uart_mmio;
  localparam int CPB = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxd = 1'b1;
  logic        txd;
  logic        overrun;
  logic        accessErr;

  int checks = 0;
  int errors = 0;
  int ovCount = 0;
  bit finished = 0;

  uart_mmio #(.ADDR_W(5), .DATA_W(32), .CLKS_PER_BIT(CPB)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxd(rxd), .txd(txd),
    .overrun(overrun), .accessErr(accessErr)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (rstN && overrun) ovCount++;

  function automatic logic [9:0] frameOf(input logic [7:0] b);
    return {1'b1, b, 1'b0};
  endfunction

  function automatic logic [31:0] statusOf(input logic rxr, input logic txr);
    return {30'd0, txr, rxr};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(posedge clk); @(negedge clk);
    busRd = 1'b0;
  endtask

  // Called at the falling edge 'elapsed' cycles after the load edge.
  task automatic txCapture(input logic [7:0] b, input int elapsed, input string tag);
    logic [9:0] got;
    logic sawReady;
    int pos;
    pos = elapsed; sawReady = 1'b0; got = '0;
    busAddr = 5'h14; busRd = 1'b1;
    for (int i = 0; i < 10; i++) begin
      while (pos < CPB/2 + i*CPB) begin @(negedge clk); pos++; end
      #1 got[i] = txd;
      if (busRdata[1]) sawReady = 1'b1;
    end
    while (pos < 10*CPB - 1) begin @(negedge clk); pos++; end
    #1 if (busRdata[1]) sawReady = 1'b1;
    chk({tag, " R2 frame"}, 32'(got), 32'(frameOf(b)));
    chk("R3 tx ready clear during frame", 32'(sawReady), 32'd0);
    @(negedge clk);
    #1 chk("R3 tx ready set after 10 bits", 32'(busRdata[1]), 32'd1);
    busRd = 1'b0;
  endtask

  task automatic rxSend(input logic [7:0] b);
    logic [9:0] f;
    f = frameOf(b);
    for (int i = 0; i < 10; i++) begin
      rxd = f[i];
      repeat (CPB) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] b;
    int ov0;
    logic idleOk;
    logic [4:0] badAddrs [7];
    badAddrs = '{5'h08, 5'h0C, 5'h10, 5'h18, 5'h1C, 5'h01, 5'h06};
    void'($urandom(32'h5EED));

    repeat (5) @(negedge clk);
    chk("R1 txd idle in reset", 32'(txd), 32'd1);
    chk("R1 no overrun", 32'(overrun), 32'd0);
    chk("R1 no access error", 32'(accessErr), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    busRead(5'h14, d); chk("R1 status reset", d, statusOf(0, 1));
    busRead(5'h04, d); chk("R1 rx data reset", d, 32'd0);
    chk("R9 mapped read raises no error", 32'(accessErr), 32'd0);

    // Directed transmit patterns
    busWrite(5'h00, 32'hFFFF_FFA5); txCapture(8'hA5, 0, "tx A5");
    busWrite(5'h00, 32'h0000_0000); txCapture(8'h00, 0, "tx 00");
    busWrite(5'h00, 32'h1234_56FF); txCapture(8'hFF, 0, "tx FF");

    // R4: second write while busy is dropped
    busWrite(5'h00, 32'h3C);
    busWrite(5'h00, 32'hC3);
    txCapture(8'h3C, 1, "R4 busy write");
    idleOk = 1'b1;
    repeat (3*CPB) begin @(negedge clk); if (txd !== 1'b1) idleOk = 1'b0; end
    chk("R4 no second frame", 32'(idleOk), 32'd1);

    // R5/R6 receive and acknowledge
    rxSend(8'h5A);
    busRead(5'h14, d); chk("R5 rx ready set", d, statusOf(1, 1));
    busRead(5'h04, d); chk("R5 rx data", d, 32'h5A);
    busRead(5'h14, d); chk("R6 rx ready cleared by read", d, statusOf(0, 1));

    // R7 overrun keeps the held byte
    ov0 = ovCount;
    rxSend(8'h11);
    rxSend(8'h22);
    chk("R7 one overrun pulse", 32'(ovCount - ov0), 32'd1);
    busRead(5'h14, d); chk("R7 ready kept", d, statusOf(1, 1));
    busRead(5'h04, d); chk("R7 held byte kept", d, 32'h11);

    // R8 status writes ignored
    rxSend(8'h77);
    busWrite(5'h14, 32'h0);
    busRead(5'h14, d); chk("R8 status write with ready set", d, statusOf(1, 1));
    busRead(5'h04, d); chk("R8 data intact", d, 32'h77);
    busWrite(5'h14, 32'hFFFF_FFFF);
    chk("R8 status write starts no tx", 32'(txd), 32'd1);
    busRead(5'h14, d); chk("R8 status write with ready clear", d, statusOf(0, 1));

    // R9 unmapped accesses
    for (int i = 0; i < 7; i++) begin
      busWrite(badAddrs[i], 32'hFFFF_FFFF);
      chk("R9 error after unmapped write", 32'(accessErr), 32'd1);
      busRead(badAddrs[i], d);
      chk("R9 unmapped read zero", d, 32'd0);
      chk("R9 error after unmapped read", 32'(accessErr), 32'd1);
      @(negedge clk);
      chk("R9 error is one cycle", 32'(accessErr), 32'd0);
    end
    chk("R9 unmapped writes start no tx", 32'(txd), 32'd1);
    busRead(5'h14, d); chk("R9 status unchanged", d, statusOf(0, 1));

    // R10 short glitch ignored
    rxd = 1'b0;
    repeat (CPB/2 - 2) @(negedge clk);
    rxd = 1'b1;
    repeat (12*CPB) @(negedge clk);
    busRead(5'h14, d); chk("R10 glitch not received", d, statusOf(0, 1));

    // Random mix
    for (int n = 0; n < 24; n++) begin
      b = 8'($urandom);
      if ($urandom % 2 == 0) begin
        busWrite(5'h00, {$urandom} & 32'hFFFF_FF00 | 32'(b));
        txCapture(b, 0, "random tx");
      end else begin
        rxSend(b);
        busRead(5'h14, d); chk("R5 random rx ready", d, statusOf(1, 1));
        busRead(5'h04, d); chk("R5 random rx data", d, 32'(b));
        busRead(5'h14, d); chk("R6 random ready cleared", d, statusOf(0, 1));
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule